// File: doc/BRIEF.md
# Up/Down Timer with Output Compare

This block is an 8-bit (width-parameterised) timer/counter built around a counter that can run up or down. A single `tick` input stands in for the selected, possibly prescaled, timer clock: the counter moves only in cycles where `tick` is high. A compare register holds a threshold that is matched against the count on every tick. The matches drive a waveform pin and a sticky compare flag. Reaching the end of a count sequence sets a sticky overflow flag.

Four waveform modes are selected by a two-bit mode field. They differ in three ways: how the counter sequences, what value acts as the end of the sequence (the fixed maximum or the compare value), and when a newly written compare value takes effect. In the two PWM modes the compare value is double buffered. A written value waits in a buffer and is copied into the active comparator only at one point in the period, so the duty cycle never changes part-way through a period.

Software uses a small register port. It can write and read the count, the compare buffer and the mode field. It reads the two flags and clears each one by writing a one to its bit.

Top module: `tmr_updown`

## Requirements
- R1: After reset the count, the compare buffer, the mode (normal) and both flags read as zero, the waveform output is low and the counter direction is up.
- R2: In a cycle where `tick` is low and no count write occurs, the count keeps its value.
- R3: In normal mode (mode 00) each tick adds one to the count, wrapping from 0xFF to 0x00, and the tick taken at 0xFF sets the overflow flag.
- R4: In clear-on-compare mode (mode 10) a tick taken while the count equals the compare value returns the count to 0x00; otherwise the count adds one, and a tick taken at 0xFF sets the overflow flag.
- R5: In fast PWM mode (mode 11) the count runs 0x00 to 0xFF and wraps, the wrap tick sets the overflow flag and drives the output high, and a compare match drives it low; when both occur on one tick the output goes high.
- R6: In phase-correct mode (mode 01) the count rises to 0xFF, then falls to 0x00, then rises again; the tick taken at 0x00 while falling sets the overflow flag.
- R7: A tick taken while the count equals the active compare value sets the compare flag (flag bit 1).
- R8: In modes 00 and 10 a written compare value is used on the next tick; in fast PWM it becomes active on the wrap tick; in phase-correct mode it becomes active on the tick taken at 0xFF while rising.
- R9: A write to the count register suppresses any compare match on the next tick, even if idle cycles intervene. A count write in the same cycle as a tick takes precedence, and that tick has no other effect.
- R10: Writing a one to flag bit 0 (overflow) or bit 1 (compare) clears that flag, and writing a zero leaves it. A flag event in the same cycle as its clear leaves the flag set.
- R11: In modes 00 and 10 every compare match inverts the waveform output.
- R12: In phase-correct mode a compare match while counting up drives the output low, and a match while counting down drives it high.
- R13: The register address map is: 0 the count, 1 the compare buffer, 2 the mode in bits [1:0], 3 the flags. Reads are combinational on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable (one timer clock) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | W | Register read data |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The properties assume `tick` and the write strobe are synchronous single-cycle qualifiers. They also assume a mode change takes effect from the cycle after its write, so every consequence is judged against the mode seen in the cycle of the triggering tick. The stimulus drives every input one half-period away from the active edge. Mode and compare values are written only between ticks, except in the deliberate same-cycle cases (count write plus tick, flag clear plus overflow). The vectors deliberately start the count above the compare value in clear-on-compare mode and next to the wrap point in the PWM modes. These starting points exercise the wrap paths without relying on any unstated behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_PHASE   = 2'b01,
        MODE_CLRCMP  = 2'b10,
        MODE_FASTPWM = 2'b11
    } tmr_mode_e;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CMP   = 2'd1;
    localparam logic [1:0] ADDR_MODE  = 2'd2;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;

    localparam int FLAG_OVF_BIT = 0;
    localparam int FLAG_CMP_BIT = 1;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] top_val,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_q,
    output logic         down_q,
    output logic         ovf_evt,
    output logic         top_evt,
    output logic         wrap_evt
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] BOTV = {W{1'b0}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ovf_evt  = 1'b0;
        top_evt  = 1'b0;
        wrap_evt = 1'b0;
        if (ld_en) begin
            st_d.cnt = ld_val;
        end else if (tick) begin
            unique case (mode)
                MODE_PHASE: begin
                    if (!st_q.down) begin
                        if (st_q.cnt == top_val) begin
                            st_d.down = 1'b1;
                            st_d.cnt  = st_q.cnt - 1'b1;
                            top_evt   = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (st_q.cnt == BOTV) begin
                            st_d.down = 1'b0;
                            st_d.cnt  = st_q.cnt + 1'b1;
                            ovf_evt   = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                MODE_CLRCMP: begin
                    st_d.cnt = (st_q.cnt == top_val) ? BOTV : st_q.cnt + 1'b1;
                    ovf_evt  = (st_q.cnt == MAXV);
                end
                default: begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    ovf_evt  = (st_q.cnt == MAXV);
                    wrap_evt = (st_q.cnt == MAXV);
                end
            endcase
        end
        if (mode != MODE_PHASE) st_d.down = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q  = st_q.cnt;
    assign down_q = st_q.down;

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm,
    input  logic         buf_we,
    input  logic [W-1:0] buf_wdata,
    input  logic [W-1:0] cnt,
    input  logic         cnt_wr,
    input  logic         reload,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] cmp_eff,
    output logic         match_evt
);

    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
        logic         blk;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (buf_we) st_d.hold = buf_wdata;
        if (!pwm || reload) st_d.act = st_q.hold;
        if (cnt_wr)    st_d.blk = 1'b1;
        else if (tick) st_d.blk = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_q     = st_q.hold;
    assign cmp_eff   = pwm ? st_q.act : st_q.hold;
    assign match_evt = tick && !cnt_wr && !st_q.blk && (cnt == cmp_eff);

endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tmr_mode_e mode,
    input  logic      match_evt,
    input  logic      wrap_evt,
    input  logic      down,
    output logic      wave_q
);

    logic w_d, w_q;

    always_comb begin
        w_d = w_q;
        unique case (mode)
            MODE_FASTPWM: begin
                if (wrap_evt)       w_d = 1'b1;
                else if (match_evt) w_d = 1'b0;
            end
            MODE_PHASE: begin
                if (match_evt) w_d = down;
            end
            default: begin
                if (match_evt) w_d = ~w_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= 1'b0;
        else        w_q <= w_d;
    end

    assign wave_q = w_q;

endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic         wave_out,
    output logic         ovf_flag,
    output logic         cmp_flag
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam int PADW = W - 2;

    typedef struct packed {
        tmr_mode_e mode;
        logic      ovf;
        logic      cmp;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic         wr_cnt, wr_cmp, wr_mode, wr_flag;
    logic [W-1:0] cnt_q, buf_q, cmp_eff, top_val;
    logic         down_q, ovf_evt, top_evt, wrap_evt, match_evt;
    logic         pwm, reload;
    tmr_mode_e    mode_q;

    assign wr_cnt  = wr_en && (wr_addr == ADDR_COUNT);
    assign wr_cmp  = wr_en && (wr_addr == ADDR_CMP);
    assign wr_mode = wr_en && (wr_addr == ADDR_MODE);
    assign wr_flag = wr_en && (wr_addr == ADDR_FLAGS);

    assign mode_q  = ctl_q.mode;
    assign pwm     = mode_q[0];
    assign top_val = (mode_q == MODE_CLRCMP) ? buf_q : MAXV;
    assign reload  = ((mode_q == MODE_FASTPWM) && wrap_evt) ||
                     ((mode_q == MODE_PHASE) && top_evt);

    tmr_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode_q),
        .top_val  (top_val),
        .ld_en    (wr_cnt),
        .ld_val   (wr_data),
        .cnt_q    (cnt_q),
        .down_q   (down_q),
        .ovf_evt  (ovf_evt),
        .top_evt  (top_evt),
        .wrap_evt (wrap_evt)
    );

    tmr_compare #(.W(W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pwm       (pwm),
        .buf_we    (wr_cmp),
        .buf_wdata (wr_data),
        .cnt       (cnt_q),
        .cnt_wr    (wr_cnt),
        .reload    (reload),
        .buf_q     (buf_q),
        .cmp_eff   (cmp_eff),
        .match_evt (match_evt)
    );

    tmr_wavegen u_wavegen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .match_evt (match_evt),
        .wrap_evt  (wrap_evt),
        .down      (down_q),
        .wave_q    (wave_out)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_mode) ctl_d.mode = tmr_mode_e'(wr_data[1:0]);
        ctl_d.ovf = ovf_evt   | (ctl_q.ovf & ~(wr_flag & wr_data[FLAG_OVF_BIT]));
        ctl_d.cmp = match_evt | (ctl_q.cmp & ~(wr_flag & wr_data[FLAG_CMP_BIT]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{mode: MODE_NORMAL, ovf: 1'b0, cmp: 1'b0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_COUNT: rd_data = cnt_q;
            ADDR_CMP:   rd_data = buf_q;
            ADDR_MODE:  rd_data = {{PADW{1'b0}}, ctl_q.mode};
            default:    rd_data = {{PADW{1'b0}}, ctl_q.cmp, ctl_q.ovf};
        endcase
    end

    assign ovf_flag = ctl_q.ovf;
    assign cmp_flag = ctl_q.cmp;

endmodule

// File: rtl/tmr_updown_chk.sv
module tmr_updown_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [1:0]   wr_bits,
    input logic [W-1:0] cnt,
    input logic [1:0]   mode,
    input logic [W-1:0] cmp_eff,
    input logic         ovf_flag,
    input logic         cmp_flag,
    input logic         wave_out
);

    localparam logic [W-1:0] MAXV  = {W{1'b1}};
    localparam logic [W-1:0] MAXM1 = MAXV - 1'b1;

    logic wr_cnt, clr_ovf, clr_cmp;
    assign wr_cnt  = wr_en && (wr_addr == 2'd0);
    assign clr_ovf = wr_en && (wr_addr == 2'd3) && wr_bits[0];
    assign clr_cmp = wr_en && (wr_addr == 2'd3) && wr_bits[1];

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode == 2'b00 && cnt == MAXV) |=> (cnt == '0 && ovf_flag));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode == 2'b10 && cnt == cmp_eff) |=> (cnt == '0));

    p_fast_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode == 2'b11 && cnt == MAXV) |=> (wave_out && ovf_flag));

    p_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode == 2'b01 && cnt == MAXV) |=> (cnt == MAXM1));

    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_cnt) && tick && !wr_cnt && !cmp_flag) |=> !cmp_flag);

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    p_cmp_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !clr_cmp) |=> cmp_flag);

endmodule

bind tmr_updown tmr_updown_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bits  (wr_data[1:0]),
    .cnt      (cnt_q),
    .mode     (mode_q),
    .cmp_eff  (cmp_eff),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag),
    .wave_out (wave_out)
);

// File: tb/tmr_updown_tb.sv
module tmr_updown_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         wave_out, ovf_flag, cmp_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_updown #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wave_out(wave_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    // reference state, built from the requirements
    logic [7:0] m_cnt, m_buf, m_act;
    logic [1:0] m_mode;
    logic       m_down, m_blk, m_ovf, m_cmpf, m_wave;

    task automatic model_reset();
        m_cnt = 0; m_buf = 0; m_act = 0; m_mode = 0;
        m_down = 0; m_blk = 0; m_ovf = 0; m_cmpf = 0; m_wave = 0;
    endtask

    task automatic cyc(input logic t, input logic we, input logic [1:0] a, input logic [7:0] d);
        logic ld, tk, pwm, match, ovf_e, topev, bot;
        logic [7:0] cv, top, n_cnt, n_act, n_buf;
        logic [1:0] n_mode;
        logic n_down, n_blk, n_ovf, n_cmpf, n_wave, clr;
        ld    = we && (a == 2'd0);
        tk    = t && !ld;
        pwm   = m_mode[0];
        cv    = pwm ? m_act : m_buf;
        top   = (m_mode == 2'd2) ? m_buf : 8'hFF;
        match = tk && !m_blk && (m_cnt == cv);
        n_cnt = m_cnt; n_down = m_down; ovf_e = 0; topev = 0; bot = 0;
        if (ld) n_cnt = d;
        else if (tk) begin
            case (m_mode)
                2'd1: begin
                    if (!m_down) begin
                        if (m_cnt == 8'hFF) begin n_down = 1; n_cnt = m_cnt - 8'd1; topev = 1; end
                        else n_cnt = m_cnt + 8'd1;
                    end else begin
                        if (m_cnt == 8'h00) begin n_down = 0; n_cnt = 8'd1; ovf_e = 1; end
                        else n_cnt = m_cnt - 8'd1;
                    end
                end
                2'd2: begin
                    n_cnt = (m_cnt == top) ? 8'd0 : m_cnt + 8'd1;
                    ovf_e = (m_cnt == 8'hFF);
                end
                default: begin
                    n_cnt = m_cnt + 8'd1;
                    ovf_e = (m_cnt == 8'hFF);
                    bot   = (m_mode == 2'd3) && (m_cnt == 8'hFF);
                end
            endcase
        end
        if (m_mode != 2'd1) n_down = 0;
        n_act  = (!pwm || bot || topev) ? m_buf : m_act;
        n_buf  = (we && a == 2'd1) ? d : m_buf;
        n_blk  = ld ? 1'b1 : (t ? 1'b0 : m_blk);
        clr    = we && (a == 2'd3);
        n_ovf  = ovf_e | (m_ovf & !(clr && d[0]));
        n_cmpf = match | (m_cmpf & !(clr && d[1]));
        case (m_mode)
            2'd3:    n_wave = bot ? 1'b1 : (match ? 1'b0 : m_wave);
            2'd1:    n_wave = match ? m_down : m_wave;
            default: n_wave = match ? ~m_wave : m_wave;
        endcase
        n_mode = (we && a == 2'd2) ? d[1:0] : m_mode;
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        m_cnt = n_cnt; m_down = n_down; m_act = n_act; m_buf = n_buf; m_blk = n_blk;
        m_ovf = n_ovf; m_cmpf = n_cmpf; m_wave = n_wave; m_mode = n_mode;
        @(negedge clk);
        tick = 0; wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; tick = 0; wr_en = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cyc(1, 0, 2'd0, 8'd0);
    endtask

    // {mode, compare value, start count, cycles}
    localparam logic [33:0] VECS [0:7] = '{
        {2'b00, 8'h10, 8'hF0, 16'd20},
        {2'b00, 8'h80, 8'h00, 16'd300},
        {2'b10, 8'h20, 8'h00, 16'd70},
        {2'b10, 8'h05, 8'h30, 16'd250},
        {2'b11, 8'h40, 8'h00, 16'd600},
        {2'b11, 8'hFF, 8'hF8, 16'd20},
        {2'b01, 8'h60, 8'h00, 16'd300},
        {2'b01, 8'h10, 8'hFA, 16'd700}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        string rq, wq;
        model_reset();

        // R1: reset state
        do_reset();
        rd(2'd0, v); chk("R1", "count", v, 0);
        rd(2'd1, v); chk("R1", "compare", v, 0);
        rd(2'd2, v); chk("R1", "mode", v, 0);
        rd(2'd3, v); chk("R1", "flags", v, 0);
        chk("R1", "wave", wave_out, 0);

        // vector walk across all modes
        for (int i = 0; i < 8; i++) begin
            logic [1:0] md; logic [7:0] oc, st; int nc;
            {md, oc, st, nc} = {VECS[i][33:32], VECS[i][31:24], VECS[i][23:16], int'(VECS[i][15:0])};
            do_reset();
            cyc(0, 1, 2'd2, {6'd0, md});
            cyc(0, 1, 2'd1, oc);
            cyc(0, 1, 2'd0, st);
            for (int k = 0; k < nc; k++) cyc((i % 2 == 0) || (k % 3 != 0), 0, 2'd0, 8'd0);
            case (md)
                2'd0: begin rq = "R3"; wq = "R11"; end
                2'd1: begin rq = "R6"; wq = "R12"; end
                2'd2: begin rq = "R4"; wq = "R11"; end
                default: begin rq = "R5"; wq = "R5"; end
            endcase
            rd(2'd0, v); chk(rq, "count", v, m_cnt);
            rd(2'd3, v); chk(rq, "overflow flag", v[0], m_ovf);
            chk("R7", "compare flag", v[1], m_cmpf);
            chk(wq, "wave", wave_out, m_wave);
            rd(2'd1, v); chk("R13", "compare readback", v, oc);
            rd(2'd2, v); chk("R13", "mode readback", v, md);
        end

        // R2: hold without tick
        do_reset();
        cyc(0, 1, 2'd0, 8'h37);
        repeat (10) cyc(0, 0, 2'd0, 8'd0);
        rd(2'd0, v); chk("R2", "count held", v, 8'h37);
        ticks(1);
        rd(2'd0, v); chk("R2", "count after tick", v, 8'h38);

        // R9: match blocked after count write
        cyc(0, 1, 2'd1, 8'h05);
        cyc(0, 1, 2'd0, 8'h05);
        repeat (3) cyc(0, 0, 2'd0, 8'd0);
        ticks(1);
        rd(2'd0, v); chk("R9", "count after blocked tick", v, 8'h06);
        chk("R9", "compare flag blocked", cmp_flag, 0);
        cyc(0, 1, 2'd0, 8'h04);
        ticks(2);
        chk("R7", "compare flag after match", cmp_flag, 1);
        chk("R11", "wave toggled", wave_out, 1);
        cyc(1, 1, 2'd0, 8'h20);
        rd(2'd0, v); chk("R9", "write wins over tick", v, 8'h20);

        // R10: write-one-to-clear
        cyc(0, 1, 2'd0, 8'hFF);
        ticks(1);
        chk("R3", "overflow at wrap", ovf_flag, 1);
        cyc(0, 1, 2'd3, 8'h00);
        rd(2'd3, v); chk("R10", "zero write keeps flags", v, 8'h03);
        cyc(0, 1, 2'd3, 8'h01);
        rd(2'd3, v); chk("R10", "overflow cleared only", v, 8'h02);
        cyc(0, 1, 2'd0, 8'hFF);
        cyc(1, 1, 2'd3, 8'h01);
        chk("R10", "set wins over clear", ovf_flag, 1);
        cyc(0, 1, 2'd3, 8'h02);
        rd(2'd3, v); chk("R10", "compare cleared only", v, 8'h01);

        // R8: fast PWM buffer loads at wrap
        do_reset();
        cyc(0, 1, 2'd2, 8'h03);
        cyc(0, 1, 2'd1, 8'h40);
        cyc(0, 1, 2'd0, 8'hFE);
        ticks(2);
        chk("R5", "wave high after wrap", wave_out, 1);
        ticks(8'h20);
        cyc(0, 1, 2'd1, 8'h30);
        ticks(8'h15);
        rd(2'd0, v); chk("R8", "count", v, 8'h35);
        chk("R8", "new value not yet active", wave_out, 1);
        ticks(8'h10);
        chk("R8", "old value clears output", wave_out, 0);
        ticks(8'hBB);
        chk("R5", "wave set on wrap", wave_out, 1);
        ticks(8'h35);
        chk("R8", "new value active after wrap", wave_out, 0);

        // R8: clear-on-compare uses the buffer directly
        do_reset();
        cyc(0, 1, 2'd2, 8'h02);
        cyc(0, 1, 2'd1, 8'h08);
        ticks(9);
        rd(2'd0, v); chk("R4", "cleared at compare", v, 8'h00);
        cyc(0, 1, 2'd1, 8'h03);
        ticks(4);
        rd(2'd0, v); chk("R8", "new top used at once", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule